// File: doc/BRIEF.md
# Three-Slot Instruction Decode Steering

This block sits between an instruction pre-decoder and three parallel decoders. Every cycle it looks at the next three instructions in program order. Each instruction arrives as a descriptor with a valid bit, a micro-op count and a microcoded flag; the head descriptor also carries a hold length. The block assigns a leading run of these instructions to the decoder slots. The upstream side then advances its window by the consumed count that the block reports.

The slots are not equal. Slot 0 takes any instruction: a single micro-op instruction, one of two to four micro-ops, or a microcoded sequence. Slots 1 and 2 take only single micro-op instructions, and only behind an instruction placed in slot 0 in the same cycle. When an instruction at a later position needs the full decoder, steering stops before it, and that instruction leads the next cycle. A microcoded instruction takes slot 0 alone and then blocks steering for a number of cycles set by its descriptor. During those cycles a busy output is raised. A back-pressure input freezes everything, so no instruction is consumed or dropped.

Top module: `decode_steer`

## Requirements
- R1: While the active-low synchronous reset `rst_n` is low at a clock edge, the consumed count, all slot valid bits and all slot micro-op counts become 0, and busy becomes 0. This also applies in the middle of a microcoded hold.
- R2: All outputs are registered: the decision on the window present at a clock edge appears after that edge. When the window holds up to three valid single micro-op instructions (micro-op count 1, not microcoded), all of them are consumed in order: position k goes to slot k, with slot k's count at bits [k*UOP_W +: UOP_W] of `slot_uops_o`.
- R3: A non-microcoded head instruction with any micro-op count, including 2 to 4, is placed in slot 0 with its count copied out. Single micro-op followers may still fill slots 1 and 2 in the same cycle.
- R4: When the instruction at position 1 or 2 is microcoded or has a micro-op count other than 1, steering stops before it. The consumed count equals its position, and it is presented again at position 0 in the next cycle.
- R5: Slot valid bits always form a prefix from slot 0, so slot k is valid only if slot k-1 is valid. The consumed count equals the number of valid slots.
- R6: A microcoded head instruction is consumed alone: consumed count 1, only slot 0 valid, even when the followers are single micro-op instructions.
- R7: A microcoded head with hold length L blocks steering for the next L-1 unfrozen cycles. In each of those cycles the consumed count is 0 and busy is 1. Busy falls after the last one and steering resumes. L of 0 or 1 gives no busy cycle.
- R8: When `hold_i` is high at an edge, the consumed count and slot valid bits become 0 and the remaining microcoded hold count does not change, so busy keeps its value.
- R9: When the head descriptor is not valid, nothing is consumed. Every slot that is not valid reports a micro-op count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Downstream back-pressure; freezes steering |
| win_vld_i | input | NSLOT | Valid bit per window position (position 0 is oldest) |
| win_mc_i | input | NSLOT | Microcoded flag per window position |
| win_uops_i | input | NSLOT*UOP_W | Micro-op count per position, position k at [k*UOP_W +: UOP_W] |
| head_len_i | input | LEN_W | Slot-0 hold length of the head descriptor when microcoded |
| take_o | output | TAKE_W | Number of window instructions consumed |
| slot_vld_o | output | NSLOT | Per-slot valid |
| slot_uops_o | output | NSLOT*UOP_W | Per-slot micro-op count, slot k at [k*UOP_W +: UOP_W] |
| busy_o | output | 1 | Slot 0 held by a microcoded instruction |

## Verification
The checker assumes that window valid bits are contiguous from position 0. It also assumes that every valid non-microcoded descriptor carries a count of at least 1, and that the upstream side shifts its window by exactly the reported consumed count before the next edge. The bench models that upstream queue. It builds descriptors only from single, two-to-four and microcoded kinds with counts in range, and it refills the window from the queue pointer after every cycle. Random hold pulses and a reset in the middle of a microcoded hold test the freeze and clear paths beyond those assumptions.

// File: rtl/ds_pkg.sv
package ds_pkg;

   // Per-cycle action of the steering block
   typedef enum logic [1:0] {
      DS_ACT_FREEZE = 2'd0,   // back-pressure: nothing moves
      DS_ACT_DRAIN  = 2'd1,   // microcoded occupancy running
      DS_ACT_STEER  = 2'd2    // normal assignment to slots
   } ds_act_e;

   localparam int unsigned DS_SLOTS_DEFAULT = 3;
   localparam int unsigned DS_UOP_W_DEFAULT = 3;
   localparam int unsigned DS_LEN_W_DEFAULT = 6;

endpackage

// File: rtl/ds_follow_steer.sv
module ds_follow_steer #(
   parameter int unsigned NSLOT = 3,
   parameter int unsigned UOP_W = 3
) (
   input  logic [NSLOT-1:0]       vld_i,
   input  logic [NSLOT-1:0]       mc_i,
   input  logic [NSLOT*UOP_W-1:0] uops_i,
   output logic [NSLOT-1:0]       grant_o
);

   // Slot 0 accepts anything valid; followers only single micro-op
   // instructions, and only while every older position was granted.
   assign grant_o[0] = vld_i[0];

   for (genvar k = 1; k < NSLOT; k++) begin : g_follow
      logic simple_k;
      assign simple_k = vld_i[k] && !mc_i[k]
                        && (uops_i[k*UOP_W +: UOP_W] == UOP_W'(1));
      if (k == 1) begin : g_first
         // a microcoded head owns the cycle alone
         assign grant_o[k] = grant_o[0] && !mc_i[0] && simple_k;
      end else begin : g_chain
         assign grant_o[k] = grant_o[k-1] && simple_k;
      end
   end

endmodule

// File: rtl/ds_mc_timer.sv
module ds_mc_timer #(
   parameter int unsigned LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             freeze_i,
   input  logic             load_i,
   input  logic [LEN_W-1:0] len_i,
   output logic             busy_o
);

   logic [LEN_W-1:0] cnt_q;
   logic [LEN_W-1:0] load_val;

   // The accept cycle is the first cycle of the hold, so L-1 remain
   assign load_val = (len_i == '0) ? '0 : len_i - LEN_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!freeze_i) begin
         if (load_i)
            cnt_q <= load_val;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - LEN_W'(1);
      end
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/decode_steer.sv
module decode_steer
   import ds_pkg::*;
#(
   parameter int unsigned NSLOT  = DS_SLOTS_DEFAULT,
   parameter int unsigned UOP_W  = DS_UOP_W_DEFAULT,
   parameter int unsigned LEN_W  = DS_LEN_W_DEFAULT,
   localparam int unsigned TAKE_W = $clog2(NSLOT + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   hold_i,
   input  logic [NSLOT-1:0]       win_vld_i,
   input  logic [NSLOT-1:0]       win_mc_i,
   input  logic [NSLOT*UOP_W-1:0] win_uops_i,
   input  logic [LEN_W-1:0]       head_len_i,
   output logic [TAKE_W-1:0]      take_o,
   output logic [NSLOT-1:0]       slot_vld_o,
   output logic [NSLOT*UOP_W-1:0] slot_uops_o,
   output logic                   busy_o
);

   if (NSLOT < 2) begin : g_bad_slots
      $error("decode_steer: NSLOT must be at least 2");
   end
   if (UOP_W < 3) begin : g_bad_uopw
      $error("decode_steer: UOP_W must hold a count of 4");
   end
   if (LEN_W < 2) begin : g_bad_lenw
      $error("decode_steer: LEN_W must be at least 2");
   end

   ds_act_e                act;
   logic [NSLOT-1:0]       grant;
   logic [TAKE_W-1:0]      take_d;
   logic [NSLOT*UOP_W-1:0] uops_d;
   logic                   mc_load;

   always_comb begin
      if (hold_i)
         act = DS_ACT_FREEZE;
      else if (busy_o)
         act = DS_ACT_DRAIN;
      else
         act = DS_ACT_STEER;
   end

   ds_follow_steer #(
      .NSLOT (NSLOT),
      .UOP_W (UOP_W)
   ) follow_i (
      .vld_i   (win_vld_i),
      .mc_i    (win_mc_i),
      .uops_i  (win_uops_i),
      .grant_o (grant)
   );

   always_comb begin
      take_d = '0;
      for (int k = 0; k < NSLOT; k++)
         take_d = take_d + TAKE_W'(grant[k]);
   end

   for (genvar k = 0; k < NSLOT; k++) begin : g_uops
      assign uops_d[k*UOP_W +: UOP_W] =
         grant[k] ? win_uops_i[k*UOP_W +: UOP_W] : '0;
   end

   assign mc_load = (act == DS_ACT_STEER) && win_vld_i[0] && win_mc_i[0];

   ds_mc_timer #(
      .LEN_W (LEN_W)
   ) timer_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze_i (hold_i),
      .load_i   (mc_load),
      .len_i    (head_len_i),
      .busy_o   (busy_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o      <= '0;
         slot_vld_o  <= '0;
         slot_uops_o <= '0;
      end else if (act == DS_ACT_STEER) begin
         take_o      <= take_d;
         slot_vld_o  <= grant;
         slot_uops_o <= uops_d;
      end else begin
         take_o      <= '0;
         slot_vld_o  <= '0;
         slot_uops_o <= '0;
      end
   end

endmodule

// File: rtl/decode_steer_chk.sv
module decode_steer_chk #(
   parameter int unsigned NSLOT  = 3,
   parameter int unsigned UOP_W  = 3,
   parameter int unsigned LEN_W  = 6,
   localparam int unsigned TAKE_W = $clog2(NSLOT + 1)
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   hold_i,
   input logic [NSLOT-1:0]       win_vld_i,
   input logic [NSLOT-1:0]       win_mc_i,
   input logic [NSLOT*UOP_W-1:0] win_uops_i,
   input logic [LEN_W-1:0]       head_len_i,
   input logic [TAKE_W-1:0]      take_o,
   input logic [NSLOT-1:0]       slot_vld_o,
   input logic [NSLOT*UOP_W-1:0] slot_uops_o,
   input logic                   busy_o
);

   assert_count_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
      32'(take_o) == $countones(slot_vld_o));

   assert_head_placed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !busy_o && win_vld_i[0] && !win_mc_i[0]) |=>
      (slot_vld_o[0] && slot_uops_o[UOP_W-1:0] == $past(win_uops_i[UOP_W-1:0])));

   assert_mc_alone_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !busy_o && win_vld_i[0] && win_mc_i[0]) |=> (take_o == TAKE_W'(1)));

   assert_mc_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !busy_o && win_vld_i[0] && win_mc_i[0] && head_len_i > LEN_W'(1))
      |=> busy_o);

   assert_busy_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (take_o == '0 || $past(!busy_o)));

   assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> (take_o == '0 && slot_vld_o == '0));

   assert_hold_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(busy_o));

   assert_empty_head_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_i && !busy_o && !win_vld_i[0]) |=> (take_o == '0));

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assert_slot_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
         !win_vld_i[k] |=> !slot_vld_o[k]);
      assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
         !slot_vld_o[k] |-> (slot_uops_o[k*UOP_W +: UOP_W] == '0));
      if (k > 0) begin : g_follow
         assert_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld_o[k] |-> slot_vld_o[k-1]);
         assert_follow_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (win_mc_i[k] || win_uops_i[k*UOP_W +: UOP_W] != UOP_W'(1)) |=> !slot_vld_o[k]);
         assert_follow_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            slot_vld_o[k] |-> (slot_uops_o[k*UOP_W +: UOP_W] == UOP_W'(1)));
      end
   end

endmodule

bind decode_steer decode_steer_chk #(
   .NSLOT (NSLOT),
   .UOP_W (UOP_W),
   .LEN_W (LEN_W)
) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .hold_i      (hold_i),
   .win_vld_i   (win_vld_i),
   .win_mc_i    (win_mc_i),
   .win_uops_i  (win_uops_i),
   .head_len_i  (head_len_i),
   .take_o      (take_o),
   .slot_vld_o  (slot_vld_o),
   .slot_uops_o (slot_uops_o),
   .busy_o      (busy_o)
);

// File: tb/decode_steer_tb.sv
`timescale 1ns/1ps
module decode_steer_tb_top;
   localparam int NS = 3;
   localparam int UW = 3;
   localparam int LW = 6;
   localparam int TW = 2;
   localparam int QMAX = 1024;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hold = 1'b0;
   logic [NS-1:0]    vld = '0;
   logic [NS-1:0]    mc = '0;
   logic [NS*UW-1:0] uops = '0;
   logic [LW-1:0]    len = '0;
   logic [TW-1:0]    take;
   logic [NS-1:0]    svld;
   logic [NS*UW-1:0] suops;
   logic             busy;

   always #2.5 clk = ~clk;

   decode_steer #(.NSLOT(NS), .UOP_W(UW), .LEN_W(LW)) dut_i (
      .clk(clk), .rst_n(rst_n), .hold_i(hold),
      .win_vld_i(vld), .win_mc_i(mc), .win_uops_i(uops), .head_len_i(len),
      .take_o(take), .slot_vld_o(svld), .slot_uops_o(suops), .busy_o(busy));

   int n_tests = 0;
   int n_fail  = 0;
   bit q_mc [QMAX];
   int q_u  [QMAX];
   int q_len[QMAX];
   int q_n = 0;
   int ptr = 0;
   int m_cnt = 0;
   int e_take;
   bit [NS-1:0] e_vld;
   int e_u [NS];
   bit e_busy;

   function automatic void push(bit m, int u, int l);
      if (q_n < QMAX) begin
         q_mc[q_n] = m; q_u[q_n] = u; q_len[q_n] = l; q_n++;
      end
   endfunction

   task automatic drive();
      for (int k = 0; k < NS; k++) begin
         int idx = ptr + k;
         vld[k] = (idx < q_n);
         mc[k]  = (idx < q_n) ? q_mc[idx] : 1'b0;
         uops[k*UW +: UW] = (idx < q_n) ? UW'(q_u[idx]) : '0;
      end
      len = (ptr < q_n) ? LW'(q_len[ptr]) : '0;
   endtask

   // Expected behaviour from the requirements
   task automatic model(input bit h);
      e_take = 0; e_vld = '0;
      for (int k = 0; k < NS; k++) e_u[k] = 0;
      if (h) begin
      end else if (m_cnt != 0) begin
         m_cnt--;
      end else if (ptr < q_n) begin
         e_vld[0] = 1'b1; e_u[0] = q_u[ptr]; e_take = 1;
         if (q_mc[ptr]) begin
            m_cnt = (q_len[ptr] == 0) ? 0 : q_len[ptr] - 1;
         end else begin
            for (int k = 1; k < NS; k++) begin
               int idx = ptr + k;
               if (e_take == k && idx < q_n && !q_mc[idx] && q_u[idx] == 1) begin
                  e_vld[k] = 1'b1; e_u[k] = 1; e_take = k + 1;
               end
            end
         end
      end
      e_busy = (m_cnt != 0);
   endtask

   task automatic check(string tag);
      bit bad = 0;
      n_tests++;
      if (take !== TW'(e_take) || svld !== e_vld || busy !== e_busy) bad = 1;
      for (int k = 0; k < NS; k++)
         if (suops[k*UW +: UW] !== UW'(e_u[k])) bad = 1;
      if (bad) begin
         n_fail++;
         $display("FAIL %s: actual take=%0d vld=%b uops=%h busy=%b expected take=%0d vld=%b uops=%0d%0d%0d busy=%b",
                  tag, take, svld, suops, busy, e_take, e_vld, e_u[2], e_u[1], e_u[0], e_busy);
      end
      n_tests++;
      if (int'(take) != $countones(svld) || (svld[1] && !svld[0]) || (svld[2] && !svld[1])) begin
         n_fail++;
         $display("FAIL R5: actual take=%0d vld=%b expected prefix with matching count", take, svld);
      end
   endtask

   task automatic cycle(input bit h, input string tag);
      hold = h;
      drive();
      model(h);
      @(posedge clk);
      @(negedge clk);
      check(tag);
      ptr += e_take;
   endtask

   task automatic reset_cycle(input string tag);
      rst_n = 1'b0;
      hold = 1'b0;
      drive();
      m_cnt = 0; e_take = 0; e_vld = '0; e_busy = 0;
      for (int k = 0; k < NS; k++) e_u[k] = 0;
      @(posedge clk);
      @(negedge clk);
      check(tag);
      rst_n = 1'b1;
   endtask

   task automatic drain(input string tag);
      int guard = 0;
      while ((ptr < q_n || m_cnt != 0) && guard < 5000) begin
         cycle(1'b0, tag);
         guard++;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++; n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0D15));
      // R1: reset with a full window presented
      push(0,1,0); push(0,1,0); push(0,1,0);
      @(negedge clk);
      reset_cycle("R1");
      reset_cycle("R1");
      // R2: three singles in one cycle
      cycle(1'b0, "R2");
      // R3: multi-uop head with two single followers
      push(0,3,0); push(0,1,0); push(0,1,0);
      cycle(1'b0, "R3");
      push(0,4,0); push(0,2,0);
      drain("R3");
      // R4: stop before a multi-uop follower, then before a microcoded one
      push(0,1,0); push(0,2,0); push(0,1,0);
      cycle(1'b0, "R4");
      drain("R4");
      push(0,1,0); push(0,1,0); push(1,5,3);
      cycle(1'b0, "R4");
      drain("R4");
      // R6/R7: microcoded head, length 4, simples behind it
      push(1,6,4); push(0,1,0); push(0,1,0);
      cycle(1'b0, "R6");
      cycle(1'b0, "R7"); cycle(1'b0, "R7"); cycle(1'b0, "R7");
      cycle(1'b0, "R7");
      // R7: lengths 0 and 1 give no busy cycle
      push(1,4,0); push(0,1,0); push(1,7,1); push(0,1,0);
      drain("R7");
      // R8: hold during a microcoded hold and during normal steering
      push(1,5,4); push(0,1,0); push(0,1,0); push(0,1,0);
      cycle(1'b0, "R6");
      cycle(1'b1, "R8"); cycle(1'b1, "R8");
      drain("R8");
      push(0,1,0); push(0,1,0);
      cycle(1'b1, "R8");
      drain("R8");
      // R9: empty window
      cycle(1'b0, "R9"); cycle(1'b0, "R9");
      // R1: reset in the middle of a microcoded hold
      push(1,4,6); push(0,1,0);
      cycle(1'b0, "R6");
      cycle(1'b0, "R7");
      reset_cycle("R1");
      drain("R1");
      // Random mix with back-pressure pulses
      for (int i = 0; i < 600; i++) begin
         int sel = $urandom_range(0, 9);
         if (sel < 6)      push(0, 1, 0);
         else if (sel < 8) push(0, $urandom_range(2, 4), 0);
         else              push(1, $urandom_range(4, 7), $urandom_range(0, 6));
      end
      begin
         int guard = 0;
         while ((ptr < q_n || m_cnt != 0) && guard < 20000) begin
            cycle($urandom_range(0, 9) == 0, "R2");
            guard++;
         end
      end
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule